// File: doc/BRIEF.md
# Nibble-Decoded Execute Unit

This block is the execute stage of a small 8-bit processor whose instructions carry a four-bit operation code in their top nibble. Each cycle it takes that code, two source operands read from the register file, and a four-bit count field from the instruction. It produces a result byte and a destination write strobe. It also produces a compare flag that the conditional-jump instruction uses to decide whether to load a new program counter.

The operations it supports are pass-through, wrapping two's-complement addition, the three bitwise operations, and rotate-right by a variable distance. Register-file access, memory, program sequencing and floating-point addition all live elsewhere. The floating-point code, like every other unsupported code, writes nothing. All three outputs are registered, so they are valid one clock after the inputs are presented. A synchronous active-high reset clears them.

Top module: `nib_exec_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next values of `res_q`, `wr_en_q` and `eq_q` are all zero.
- R2: Code 0x4 copies `src_a` to the result with the write strobe set.
- R3: Code 0x5 gives `(src_a + src_b) mod 256` with the write strobe set, and the carry is dropped. For example, 0x08 plus 0xFF gives 0x07.
- R4: Code 0x7 gives bitwise OR, 0x8 gives bitwise AND and 0x9 gives bitwise XOR of the two operands, each with the write strobe set. For example, 0x9D OR 0x17 gives 0x9F.
- R5: Code 0xA rotates `src_a` right by `rot_cnt mod 8` places with the write strobe set. Bit 0 re-enters at bit 7. A count of 0 or 8 leaves the value unchanged, 0x9D by 1 gives 0xCE, and 0x9D by 2 gives 0x67.
- R6: Code 0xB sets no write strobe and gives a zero result. `eq_q` is 1 exactly when `src_a` equals `src_b`, where `src_b` is the register-0 operand.
- R7: Codes 0x0 to 0x3, 0x6 and 0xC to 0xF give a zero result, no write strobe and `eq_q` at 0.
- R8: Every output reflects the inputs sampled at the previous rising edge. There is exactly one register stage.
- R9: `eq_q` is 0 whenever the sampled code is not 0xB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 4 | Operation code nibble |
| src_a | input | 8 | First operand (the rotated or passed value) |
| src_b | input | 8 | Second operand (register 0 for the compare) |
| rot_cnt | input | 4 | Rotate distance nibble |
| res_q | output | 8 | Registered result byte |
| wr_en_q | output | 1 | Registered destination write strobe |
| eq_q | output | 1 | Registered compare flag for the conditional jump |

## Verification
The bench builds the unit with its default 8-bit data path and 4-bit count. At that size every one of the sixteen codes can be combined with all sixteen rotate counts, including the counts of 8 and above that wrap, and with a spread grid of operand pairs. The grid includes equal pairs for the compare and pairs whose sum carries out of bit 7. Directed cases cover the worked values given in the requirements.

// File: rtl/nib_exec_pkg.sv
package nib_exec_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_PASS = 4'h4;
  localparam logic [OPC_W-1:0] OPC_ADD  = 4'h5;
  localparam logic [OPC_W-1:0] OPC_OR   = 4'h7;
  localparam logic [OPC_W-1:0] OPC_AND  = 4'h8;
  localparam logic [OPC_W-1:0] OPC_XOR  = 4'h9;
  localparam logic [OPC_W-1:0] OPC_ROR  = 4'hA;
  localparam logic [OPC_W-1:0] OPC_BEQ  = 4'hB;

  typedef enum logic [2:0] {
    FN_NONE = 3'd0,
    FN_PASS = 3'd1,
    FN_ADD  = 3'd2,
    FN_OR   = 3'd3,
    FN_AND  = 3'd4,
    FN_XOR  = 3'd5,
    FN_ROR  = 3'd6,
    FN_CMP  = 3'd7
  } fn_e;

  typedef struct packed {
    fn_e  fn;
    logic wr;
    logic cmp;
  } dec_t;

endpackage

// File: rtl/nib_op_decode.sv
module nib_op_decode
  import nib_exec_pkg::*;
(
  input  logic [OPC_W-1:0] op_code,
  output dec_t             dec
);

  always_comb begin
    dec.fn  = FN_NONE;
    dec.wr  = 1'b0;
    dec.cmp = 1'b0;
    case (op_code)
      OPC_PASS: begin dec.fn = FN_PASS; dec.wr = 1'b1; end
      OPC_ADD:  begin dec.fn = FN_ADD;  dec.wr = 1'b1; end
      OPC_OR:   begin dec.fn = FN_OR;   dec.wr = 1'b1; end
      OPC_AND:  begin dec.fn = FN_AND;  dec.wr = 1'b1; end
      OPC_XOR:  begin dec.fn = FN_XOR;  dec.wr = 1'b1; end
      OPC_ROR:  begin dec.fn = FN_ROR;  dec.wr = 1'b1; end
      OPC_BEQ:  begin dec.fn = FN_CMP;  dec.cmp = 1'b1; end
      default:  begin dec.fn = FN_NONE; end
    endcase
  end

endmodule

// File: rtl/nib_alu_core.sv
module nib_alu_core
  import nib_exec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  fn_e               fn,
  output logic [DATA_W-1:0] out
);

  logic [DATA_W:0] sum_full;

  assign sum_full = {1'b0, opa} + {1'b0, opb};

  always_comb begin
    case (fn)
      FN_PASS: out = opa;
      FN_ADD:  out = sum_full[DATA_W-1:0];
      FN_OR:   out = opa | opb;
      FN_AND:  out = opa & opb;
      FN_XOR:  out = opa ^ opb;
      default: out = '0;
    endcase
  end

  logic carry_drop;
  assign carry_drop = sum_full[DATA_W];

endmodule

// File: rtl/nib_rotr.sv
module nib_rotr #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] stg [0:CNT_W];

  assign stg[0] = din;

  for (genvar k = 0; k < CNT_W; k++) begin : g_stage
    localparam int SH = (2 ** k) % DATA_W;
    if (SH == 0) begin : g_wrap
      assign stg[k+1] = cnt[k] ? stg[k] : stg[k];
    end else begin : g_rot
      assign stg[k+1] = cnt[k] ? {stg[k][SH-1:0], stg[k][DATA_W-1:SH]} : stg[k];
    end
  end

  assign dout = stg[CNT_W];

endmodule

// File: rtl/nib_exec_unit.sv
module nib_exec_unit
  import nib_exec_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [CNT_W-1:0]  rot_cnt,
  output logic [DATA_W-1:0] res_q,
  output logic              wr_en_q,
  output logic              eq_q
);

  dec_t              dec;
  logic [DATA_W-1:0] alu_out;
  logic [DATA_W-1:0] rot_out;
  logic [DATA_W-1:0] res_d;
  logic              eq_d;

  nib_op_decode i_dec (
    .op_code (op_code),
    .dec     (dec)
  );

  nib_alu_core #(.DATA_W(DATA_W)) i_alu (
    .opa (src_a),
    .opb (src_b),
    .fn  (dec.fn),
    .out (alu_out)
  );

  nib_rotr #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_rot (
    .din  (src_a),
    .cnt  (rot_cnt),
    .dout (rot_out)
  );

  assign res_d = (dec.fn == FN_ROR) ? rot_out : alu_out;
  assign eq_d  = dec.cmp && (src_a == src_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      wr_en_q <= 1'b0;
      eq_q    <= 1'b0;
    end else begin
      res_q   <= res_d;
      wr_en_q <= dec.wr;
      eq_q    <= eq_d;
    end
  end

endmodule

// File: rtl/nib_exec_chk.sv
module nib_exec_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_code,
  input logic [DATA_W-1:0] src_a,
  input logic [CNT_W-1:0]  rot_cnt,
  input logic [DATA_W-1:0] res_q,
  input logic              wr_en_q,
  input logic              eq_q
);

  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'h4) |=> (res_q == $past(src_a) && wr_en_q));

  p_rot_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'hA && rot_cnt == '0) |=> (res_q == $past(src_a) && wr_en_q));

  p_branch_nowr_r6: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'hB) |=> (!wr_en_q && res_q == '0));

  p_unused_r7: assert property (@(posedge clk) disable iff (rst)
    (op_code < 4'h4 || op_code == 4'h6 || op_code > 4'hB)
      |=> (!wr_en_q && !eq_q && res_q == '0));

  p_eq_branch_only_r9: assert property (@(posedge clk) disable iff (rst)
    (op_code != 4'hB) |=> !eq_q);

endmodule

bind nib_exec_unit nib_exec_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_chk (
  .clk     (clk),
  .rst     (rst),
  .op_code (op_code),
  .src_a   (src_a),
  .rot_cnt (rot_cnt),
  .res_q   (res_q),
  .wr_en_q (wr_en_q),
  .eq_q    (eq_q)
);

// File: tb/test_nib_exec_unit.sv
module test_nib_exec_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_code = '0;
  logic [7:0] src_a = '0;
  logic [7:0] src_b = '0;
  logic [3:0] rot_cnt = '0;
  logic [7:0] res_q;
  logic       wr_en_q;
  logic       eq_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  nib_exec_unit i_nib_exec_unit (
    .clk (clk), .rst (rst), .op_code (op_code), .src_a (src_a),
    .src_b (src_b), .rot_cnt (rot_cnt), .res_q (res_q),
    .wr_en_q (wr_en_q), .eq_q (eq_q)
  );

  function automatic logic [7:0] ref_res(input logic [3:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic [3:0] c);
    logic [7:0] v;
    int n;
    case (op)
      4'h4: return a;
      4'h5: return 8'((int'(a) + int'(b)) % 256);
      4'h7: return a | b;
      4'h8: return a & b;
      4'h9: return a ^ b;
      4'hA: begin
        v = a;
        n = int'(c) % 8;
        for (int i = 0; i < n; i++) v = {v[0], v[7:1]};
        return v;
      end
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic ref_wr(input logic [3:0] op);
    return (op == 4'h4 || op == 4'h5 || op == 4'h7 || op == 4'h8 ||
            op == 4'h9 || op == 4'hA);
  endfunction

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'h4: return "R2";
      4'h5: return "R3";
      4'h7, 4'h8, 4'h9: return "R4";
      4'hA: return "R5";
      4'hB: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Drive on falling edge, capture edge follows, sample on next falling edge (R8).
  task automatic apply(input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [3:0] c);
    op_code = op; src_a = a; src_b = b; rot_cnt = c;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_one(input logic [3:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic [3:0] c);
    string t;
    apply(op, a, b, c);
    t = tag_of(op);
    check(t, "result", int'(res_q), int'(ref_res(op, a, b, c)));
    check(t, "write", int'(wr_en_q), int'(ref_wr(op)));
    check((op == 4'hB) ? "R6" : "R9", "eq", int'(eq_q), int'(op == 4'hB && a == b));
  endtask

  initial begin
    rst = 1'b1;
    op_code = 4'h5; src_a = 8'hFF; src_b = 8'h01; rot_cnt = 4'h1;
    @(negedge clk);
    @(negedge clk);
    // R1: reset holds outputs at zero despite a writing code on the inputs
    check("R1", "result", int'(res_q), 0);
    check("R1", "write", int'(wr_en_q), 0);
    check("R1", "eq", int'(eq_q), 0);
    rst = 1'b0;

    // Directed worked values
    apply(4'h5, 8'h08, 8'hFF, 4'h0);
    check("R3", "08+FF", int'(res_q), 8'h07);
    apply(4'h7, 8'h9D, 8'h17, 4'h0);
    check("R4", "9D|17", int'(res_q), 8'h9F);
    apply(4'hA, 8'h9D, 8'h00, 4'h1);
    check("R5", "ror1", int'(res_q), 8'hCE);
    apply(4'hA, 8'h9D, 8'h00, 4'h2);
    check("R5", "ror2", int'(res_q), 8'h67);
    apply(4'hA, 8'h9D, 8'h00, 4'h0);
    check("R5", "ror0", int'(res_q), 8'h9D);
    apply(4'hA, 8'h9D, 8'h00, 4'h8);
    check("R5", "ror8", int'(res_q), 8'h9D);
    apply(4'hA, 8'h9D, 8'h00, 4'h9);
    check("R5", "ror9", int'(res_q), 8'hCE);
    apply(4'hB, 8'h3C, 8'h3C, 4'h0);
    check("R6", "eq", int'(eq_q), 1);
    check("R6", "write", int'(wr_en_q), 0);
    apply(4'h6, 8'h12, 8'h34, 4'h0);
    check("R7", "fadd write", int'(wr_en_q), 0);
    check("R7", "fadd result", int'(res_q), 0);

    // R8: back-to-back codes, each result lands exactly one edge later
    apply(4'h4, 8'hA5, 8'h00, 4'h0);
    check("R8", "pass", int'(res_q), 8'hA5);
    apply(4'h9, 8'hA5, 8'hFF, 4'h0);
    check("R8", "xor", int'(res_q), 8'h5A);

    // Near-exhaustive sweep: all codes, all counts, operand grid incl. equal pairs
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++)
          for (int c = 0; c < 16; c++) begin
            logic [7:0] a, b;
            a = 8'((i * 37 + 3) % 256);
            b = (j == 0) ? a : 8'((j * 53 + 8) % 256);
            run_one(4'(op), a, b, 4'(c));
          end

    // R1 again mid-run
    op_code = 4'h4; src_a = 8'h77;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "mid-run result", int'(res_q), 0);
    check("R1", "mid-run write", int'(wr_en_q), 0);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule